// File: doc/BRIEF.md
# Ownership-Map Store Checker

This block sits between a small microcontroller core and its data RAM and decides, for each flagged store, whether the store may reach memory. Data memory is split into 8-byte blocks. Each block has a 4-bit ownership record, and these records are packed two to a byte in a table that lives in ordinary RAM at a base address set by software. When the fetch decoder flags a store issued by a domain that is not trusted, the checker holds the CPU and borrows the RAM port to read the record that covers the target block. It then compares the recorded owner with the domain that issued the store.

If the issuing domain owns the block, the held store goes to RAM in the third cycle. If it does not, the store is dropped, a single-cycle violation pulse is raised and the faulting address is latched. Stores from the trusted domain and writes that carry no store strobe go straight through in the same cycle, with no stall. The core boots into the trusted domain.

Top module: `own_map_store_guard`

## Requirements
- R1: After reset, `cpu_stall` and `viol_pulse` are low and `viol_addr` is zero.
- R2: In the cycle a checked store is flagged, `ram_addr` equals `map_base + (cpu_addr >> 4)`. This is the byte that holds the record for block `cpu_addr[11:3]`.
- R3: An even block number (bit 3 of the address clear) uses map byte bits [3:0], and an odd block number uses bits [7:4]. Within a record, bits [3:1] hold the owner domain and bit 0 is a segment-start flag that plays no part in the decision.
- R4: A checked store holds `cpu_stall` high for exactly two cycles, the flag cycle and the lookup cycle, and its outcome appears in the third cycle with `cpu_stall` low.
- R5: While `cpu_stall` is high, `ram_wr_en` is low.
- R6: When the record owner equals the domain that issued the store, the third cycle drives `ram_addr` with the store address and `ram_wr_en` high, and `viol_pulse` stays low.
- R7: When the owner differs, the third cycle keeps `ram_wr_en` low and raises `viol_pulse` for that cycle only. `viol_addr` takes the faulting address and holds it until the next violation.
- R8: A store from domain 0 (the trusted domain) is never stalled. `ram_addr` follows `cpu_addr` and `ram_wr_en` follows `cpu_wr_en` in the same cycle, and no violation is raised.
- R9: A write without `st_instr` passes through unchecked, with no stall, even from an untrusted domain.
- R10: The domain ID and address are captured in the flag cycle. A change of `cur_dom` during the lookup cycle does not alter the outcome.
- R11: The store strobe still being asserted during the outcome cycle does not start a second check. Once the strobe is gone, the next cycle has no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_instr | input | 1 | Fetch decoder marks the current write as a store instruction |
| cpu_wr_en | input | 1 | CPU data write enable |
| cpu_addr | input | 12 | CPU data address |
| cur_dom | input | 3 | Domain ID of the code now executing |
| map_base | input | 12 | RAM byte address where the ownership table starts |
| ram_rd_data | input | 8 | RAM read data, one cycle after the address |
| ram_addr | output | 12 | Address presented to data RAM |
| ram_wr_en | output | 1 | Write enable presented to data RAM |
| cpu_stall | output | 1 | Holds the CPU while a check is in progress |
| viol_pulse | output | 1 | One-cycle flag for a denied store |
| viol_addr | output | 12 | Address of the most recently denied store |

## Verification
Two things can coincide. In the outcome cycle, the CPU still presents the stalled store, with its strobe high, while the checker either releases that store or drops it. The bench keeps the strobe asserted through all three cycles of each store and starts the next vector's store in the very next cycle. It judges each case on three points: the release or drop happens once, no third stall cycle appears, and a new store flagged immediately afterwards gets its own fresh two-cycle stall. A separate directed step lowers the strobe after the outcome cycle and checks that the following cycle is free of stall and violation.

// File: rtl/om_pkg.sv
package om_pkg;

    localparam int ADDR_W = 12;
    localparam int DOM_W  = 3;
    localparam int OFS_W  = 3;
    localparam int REC_W  = DOM_W + 1;
    localparam int MAP_W  = 2 * REC_W;
    localparam int IDX_SHIFT = OFS_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DOM_W-1:0]  dom_t;
    typedef logic [REC_W-1:0]  rec_t;
    typedef logic [MAP_W-1:0]  map_byte_t;

    typedef struct packed {
        addr_t addr;
        dom_t  dom;
    } store_req_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_PASS,
        ST_DENY
    } chk_state_e;

    function automatic addr_t map_byte_addr(addr_t base, addr_t wr);
        return base + addr_t'(wr >> IDX_SHIFT);
    endfunction

    function automatic rec_t pick_rec(map_byte_t b, logic hi);
        return hi ? b[MAP_W-1:REC_W] : b[REC_W-1:0];
    endfunction

endpackage

// File: rtl/om_addr_map.sv
module om_addr_map
    import om_pkg::*;
(
    input  addr_t wr_addr,
    input  addr_t map_base,
    output addr_t map_addr,
    output logic  nib_hi
);
    always_comb begin
        map_addr = map_byte_addr(map_base, wr_addr);
        nib_hi   = wr_addr[OFS_W];
    end
endmodule

// File: rtl/om_owner_cmp.sv
module om_owner_cmp
    import om_pkg::*;
(
    input  map_byte_t map_byte,
    input  logic      nib_hi,
    input  dom_t      req_dom,
    output logic      owner_ok
);
    localparam rec_t OWNER_MASK = {{DOM_W{1'b1}}, 1'b0};

    rec_t rec;

    always_comb begin
        rec      = pick_rec(map_byte, nib_hi);
        owner_ok = ((rec ^ {req_dom, 1'b0}) & OWNER_MASK) == '0;
    end
endmodule

// File: rtl/om_guard_fsm.sv
module om_guard_fsm
    import om_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  store_req_t req_in,
    input  logic       owner_ok,
    output chk_state_e state,
    output store_req_t req_held,
    output addr_t      viol_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req_held  <= '0;
            viol_addr <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_LOOK;
                    req_held <= req_in;
                end
                ST_LOOK: if (owner_ok) begin
                    state <= ST_PASS;
                end else begin
                    state     <= ST_DENY;
                    viol_addr <= req_held.addr;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_LOOK_RESOLVES: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOOK |=> (state == ST_PASS || state == ST_DENY)); // R4

    AST_OUTCOME_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS || state == ST_DENY) |=> state == ST_IDLE); // R11

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOOK |=> $stable(req_held)); // R10
endmodule

// File: rtl/own_map_store_guard.sv
module own_map_store_guard
    import om_pkg::*;
#(
    parameter logic [DOM_W-1:0] TRUSTED_DOM = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_instr,
    input  logic              cpu_wr_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DOM_W-1:0]  cur_dom,
    input  logic [ADDR_W-1:0] map_base,
    input  logic [MAP_W-1:0]  ram_rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_wr_en,
    output logic              cpu_stall,
    output logic              viol_pulse,
    output logic [ADDR_W-1:0] viol_addr
);
    chk_state_e state;
    store_req_t req_in, req_held;
    addr_t      look_addr, map_addr;
    logic       nib_hi, owner_ok, start;

    assign req_in    = '{addr: cpu_addr, dom: cur_dom};
    assign start     = (state == ST_IDLE) && st_instr && cpu_wr_en && (cur_dom != TRUSTED_DOM);
    assign look_addr = (state == ST_LOOK) ? req_held.addr : cpu_addr;

    om_addr_map u_addr_map (
        .wr_addr  (look_addr),
        .map_base (map_base),
        .map_addr (map_addr),
        .nib_hi   (nib_hi)
    );

    om_owner_cmp u_owner_cmp (
        .map_byte (ram_rd_data),
        .nib_hi   (nib_hi),
        .req_dom  (req_held.dom),
        .owner_ok (owner_ok)
    );

    om_guard_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_in    (req_in),
        .owner_ok  (owner_ok),
        .state     (state),
        .req_held  (req_held),
        .viol_addr (viol_addr)
    );

    always_comb begin
        ram_addr   = cpu_addr;
        ram_wr_en  = cpu_wr_en;
        cpu_stall  = 1'b0;
        viol_pulse = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                ram_addr  = map_addr;
                ram_wr_en = 1'b0;
                cpu_stall = 1'b1;
            end
            ST_LOOK: begin
                ram_addr  = map_addr;
                ram_wr_en = 1'b0;
                cpu_stall = 1'b1;
            end
            ST_PASS: begin
                ram_addr  = req_held.addr;
                ram_wr_en = 1'b1;
            end
            default: begin
                ram_wr_en  = 1'b0;
                viol_pulse = 1'b1;
            end
        endcase
    end

    AST_STALL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> !ram_wr_en); // R5

    AST_STALL_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_stall) |=> cpu_stall); // R4

    AST_VIOL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |=> !viol_pulse); // R7

    AST_DENY_DROPS: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |-> (!ram_wr_en && !cpu_stall)); // R7

    AST_TRUSTED_FREE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cur_dom == TRUSTED_DOM) |-> !cpu_stall); // R8
endmodule

// File: tb/own_map_store_guard_test.sv
module own_map_store_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] BASE = 12'h600;
    localparam int NVEC = 8;
    // {expect_ok, domain, address}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 3'd5, 12'h100},
        {1'b1, 3'd6, 12'h108},
        {1'b0, 3'd5, 12'h10F},
        {1'b1, 3'd1, 12'h000},
        {1'b0, 3'd2, 12'h007},
        {1'b1, 3'd1, 12'hFF8},
        {1'b0, 3'd7, 12'h5F0},
        {1'b0, 3'd3, 12'h038}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_instr = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [2:0]  cur_dom = '0;
    logic [7:0]  ram_rd_data = '0;
    logic [11:0] ram_addr, viol_addr;
    logic        ram_wr_en, cpu_stall, viol_pulse;
    logic [7:0]  mem [4096];
    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) ram_rd_data <= mem[ram_addr];

    own_map_store_guard uut (
        .clk(clk), .rst(rst), .st_instr(st_instr), .cpu_wr_en(cpu_wr_en),
        .cpu_addr(cpu_addr), .cur_dom(cur_dom), .map_base(BASE),
        .ram_rd_data(ram_rd_data), .ram_addr(ram_addr), .ram_wr_en(ram_wr_en),
        .cpu_stall(cpu_stall), .viol_pulse(viol_pulse), .viol_addr(viol_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic run_store(input logic [11:0] a, input logic [2:0] d, input bit exp_ok);
        logic [11:0] exp_map = BASE + (a >> 4);
        @(negedge clk);
        st_instr = 1'b1; cpu_wr_en = 1'b1; cpu_addr = a; cur_dom = d;
        #1;
        chk(cpu_stall == 1'b1, "R4 stall in flag cycle", 32'(cpu_stall), 1);
        chk(ram_addr == exp_map, "R2 map byte address", 32'(ram_addr), 32'(exp_map));
        chk(ram_wr_en == 1'b0, "R5 write held in flag cycle", 32'(ram_wr_en), 0);
        @(negedge clk); #1;
        chk(cpu_stall == 1'b1, "R4 stall in lookup cycle", 32'(cpu_stall), 1);
        chk(ram_wr_en == 1'b0, "R5 write held in lookup cycle", 32'(ram_wr_en), 0);
        @(negedge clk); #1;
        chk(cpu_stall == 1'b0, "R11 no stall in outcome cycle", 32'(cpu_stall), 0);
        if (exp_ok) begin
            chk(ram_wr_en == 1'b1, "R6 R3 allowed store released", 32'(ram_wr_en), 1);
            chk(ram_addr == a, "R6 released store address", 32'(ram_addr), 32'(a));
            chk(viol_pulse == 1'b0, "R6 no violation", 32'(viol_pulse), 0);
        end else begin
            chk(ram_wr_en == 1'b0, "R7 R3 denied store dropped", 32'(ram_wr_en), 0);
            chk(viol_pulse == 1'b1, "R7 violation pulse", 32'(viol_pulse), 1);
            chk(viol_addr == a, "R7 faulting address", 32'(viol_addr), 32'(a));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
        for (int b = 0; b < 512; b++) begin
            logic [3:0] rec;
            rec = {3'((b % 7) + 1), 1'(b >> 1)};
            if (b % 2 == 1) mem[BASE + 12'(b / 2)][7:4] = rec;
            else            mem[BASE + 12'(b / 2)][3:0] = rec;
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cpu_stall == 1'b0, "R1 stall after reset", 32'(cpu_stall), 0);
        chk(viol_pulse == 1'b0, "R1 violation after reset", 32'(viol_pulse), 0);
        chk(viol_addr == 12'h000, "R1 fault address after reset", 32'(viol_addr), 0);

        for (int i = 0; i < NVEC; i++)
            run_store(VEC[i][11:0], VEC[i][14:12], VEC[i][15]);

        // strobe removed after the outcome cycle: no new check, pulse gone
        @(negedge clk);
        st_instr = 1'b0; cpu_wr_en = 1'b0;
        #1;
        chk(cpu_stall == 1'b0, "R11 no retrigger", 32'(cpu_stall), 0);
        chk(viol_pulse == 1'b0, "R7 pulse lasts one cycle", 32'(viol_pulse), 0);

        // trusted domain store to a block owned by domain 2
        @(negedge clk);
        st_instr = 1'b1; cpu_wr_en = 1'b1; cpu_addr = 12'h5F0; cur_dom = 3'd0;
        #1;
        chk(cpu_stall == 1'b0, "R8 trusted not stalled", 32'(cpu_stall), 0);
        chk(ram_wr_en == 1'b1, "R8 trusted write passes", 32'(ram_wr_en), 1);
        chk(ram_addr == 12'h5F0, "R8 trusted address passes", 32'(ram_addr), 32'h5F0);
        @(negedge clk); #1;
        chk(viol_pulse == 1'b0, "R8 trusted no violation", 32'(viol_pulse), 0);
        chk(viol_addr == 12'h038, "R7 fault address held", 32'(viol_addr), 32'h038);

        // write without store strobe from an untrusted non-owner
        @(negedge clk);
        st_instr = 1'b0; cpu_wr_en = 1'b1; cpu_addr = 12'h100; cur_dom = 3'd3;
        #1;
        chk(cpu_stall == 1'b0, "R9 unflagged write not stalled", 32'(cpu_stall), 0);
        chk(ram_wr_en == 1'b1 && ram_addr == 12'h100, "R9 unflagged write passes", 32'(ram_addr), 32'h100);
        @(negedge clk); #1;
        chk(viol_pulse == 1'b0, "R9 unflagged no violation", 32'(viol_pulse), 0);

        // domain changes during the lookup cycle
        @(negedge clk);
        st_instr = 1'b1; cpu_wr_en = 1'b1; cpu_addr = 12'h100; cur_dom = 3'd5;
        @(negedge clk);
        cur_dom = 3'd2;
        @(negedge clk); #1;
        chk(ram_wr_en == 1'b1, "R10 captured domain decides", 32'(ram_wr_en), 1);
        chk(viol_pulse == 1'b0, "R10 no violation after domain change", 32'(viol_pulse), 0);
        @(negedge clk);
        st_instr = 1'b0; cpu_wr_en = 1'b0;
        #1;
        chk(cpu_stall == 1'b0, "R11 idle after release", 32'(cpu_stall), 0);

        finish_run();
    end
endmodule